// File: doc/BRIEF.md
# Transmit Burst Tail-Flush Sequencer

This block sits between a host that writes characters with a strobe and a transmitter whose character FIFO uses that strobe as its write clock. The FIFO latches the bus on a rising write edge and stores it on the falling edge. Its pointers only advance on the rising edge of the next write, so the last character of a burst stays stuck until another write comes. The sequencer runs on a system clock and turns each accepted host write into a write strobe that is high for one cycle, with the data and command fields held steady around it.

When the host marks a write as the end of a burst, the sequencer waits a programmable number of idle cycles. It then issues one extra write that carries a SYNC command character. That extra write commits the tail character before the next burst begins. A host write that arrives while the flush is still pending makes the flush unnecessary, so the flush is dropped. A host write that collides with the flush write is held off until the flush strobe has fallen.

Each host write is answered with a one-cycle acknowledge pulse after a programmable delay. The host waits for this pulse before its next write, so the delay sets the write rate. It is chosen so that the FIFO can never fill faster than characters leave.

Top module: `tx_tail_flush`

## Requirements
- R1: While reset is asserted, and right after it is released, `fifo_wr_stb`, `host_ack`, `fifo_data`, `fifo_cmd` and `fifo_is_cmd` are all zero.
- R2: A host write sampled at clock edge E0 (`host_stb` high) produces a `fifo_wr_stb` pulse that is high for exactly the one cycle following edge E0+1. During that cycle, `fifo_data` and `fifo_cmd` carry the sampled `host_data` and `host_cmd`.
- R3: `fifo_data` and `fifo_cmd` change only in a cycle in which `fifo_wr_stb` is high. Between writes they hold their last values.
- R4: `fifo_is_cmd` is 1 exactly when `fifo_cmd` is non-zero. An all-zero command field marks a data character.
- R5: Between any two write strobes, `fifo_wr_stb` is low for at least one cycle.
- R6: Let L be the edge at which an end-of-burst write (`host_eob` = 1) is launched, and let N be `cfg_idle_cycles`. If no host write arrives before the flush, a flush write is launched at edge L + max(2, N+1). The flush write has `fifo_cmd` = SYNC_CODE (default 4'h8), `fifo_data` = 0 and `fifo_is_cmd` = 1.
- R7: A write with `host_eob` = 0 is never followed by a flush write.
- R8: A host write that is sampled while the flush is pending, before its launch edge, cancels the flush. Only the host write is emitted, with the normal latency from R2.
- R9: A host write that is sampled at the flush launch edge is held off. Its strobe follows the one cycle after edge E0+2 instead of E0+1, and the SYNC write goes out first.
- R10: A host write sampled at edge E0 gives a `host_ack` pulse that is high for one cycle, in the cycle following edge E0 + `cfg_ack_delay`. A delay of 0 gives the pulse right after E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_idle_cycles | input | CNT_W | Idle cycles to wait after an end-of-burst write before flushing |
| cfg_ack_delay | input | CNT_W | Cycles from host write to acknowledge |
| host_stb | input | 1 | Host write request, one cycle per character |
| host_eob | input | 1 | Marks the current write as the last of a burst |
| host_data | input | DATA_W | Host data character |
| host_cmd | input | CMD_W | Host command field, zero for data |
| host_ack | output | 1 | Delayed acknowledge pulse |
| fifo_wr_stb | output | 1 | Write strobe used as FIFO write clock |
| fifo_data | output | DATA_W | Data bus to FIFO |
| fifo_cmd | output | CMD_W | Command bus to FIFO |
| fifo_is_cmd | output | 1 | High when the bus holds a command character |

## Verification
The tests feed lone writes that differ in data, command value, end-of-burst flag, idle count and acknowledge delay. Writes without the flag must give a single strobe. Writes with the flag must give a SYNC write at an offset that follows the idle count, so the fixed two-edge floor (N = 0 and 1) is told apart from the counted wait (N = 3, 5, 9). A host write that lands inside the idle window must cancel the flush. A host write that lands exactly on the flush launch edge must be delayed by one cycle behind the SYNC write. Together these two cases separate cancel from hold-off. The acknowledge is checked in every cycle of every test, so an off-by-one in the delay count shows up at once.

// File: rtl/tf_pkg.sv
package tf_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/tf_ack_delay.sv
module tf_ack_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [CNT_W-1:0] cfg_delay,
  output logic             ack
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             ack_q, ack_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    ack_d  = 1'b0;
    if (stb) begin
      if (cfg_delay == '0) begin
        ack_d  = 1'b1;
        busy_d = 1'b0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = cfg_delay;
      end
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        ack_d  = 1'b1;
        busy_d = 1'b0;
      end
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      ack_q  <= ack_d;
    end
  end

  assign ack = ack_q;
endmodule

// File: rtl/tf_hold_slot.sv
module tf_hold_slot #(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              eob_in,
  input  logic              take,
  output logic              vld,
  output logic [DATA_W-1:0] data,
  output logic [CMD_W-1:0]  cmd,
  output logic              eob
);
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              eob_q;

  always_comb begin
    vld_d = vld_q;
    if (load)      vld_d = 1'b1;
    else if (take) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      cmd_q  <= '0;
      eob_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        data_q <= data_in;
        cmd_q  <= cmd_in;
        eob_q  <= eob_in;
      end
    end
  end

  assign vld  = vld_q;
  assign data = data_q;
  assign cmd  = cmd_q;
  assign eob  = eob_q;
endmodule

// File: rtl/tf_flush_fsm.sv
module tf_flush_fsm
  import tf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_stb,
  input  logic             slot_vld,
  input  logic             slot_eob,
  input  logic             out_busy,
  input  logic [CNT_W-1:0] cfg_idle,
  output logic             launch_host,
  output logic             launch_sync
);
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // A pending host write goes out whenever the strobe is low; the
  // flush only fires from the wait state with the slot empty.
  assign launch_host = slot_vld && !out_busy;
  assign launch_sync = (state_q == SEQ_WAIT) && !slot_vld && !out_busy &&
                       (cnt_q >= cfg_idle);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (launch_host) begin
      state_d = slot_eob ? SEQ_WAIT : SEQ_IDLE;
      cnt_d   = '0;
    end else if (launch_sync) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
    end else if (state_q == SEQ_WAIT) begin
      if (host_stb || slot_vld) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end else if (cnt_q != '1) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/tf_out_stage.sv
module tf_out_stage #(
  parameter int              DATA_W    = 8,
  parameter int              CMD_W     = 4,
  parameter logic [CMD_W-1:0] SYNC_CODE = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_host,
  input  logic              launch_sync,
  input  logic [DATA_W-1:0] slot_data,
  input  logic [CMD_W-1:0]  slot_cmd,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic [CMD_W-1:0]  wr_cmd,
  output logic              wr_is_cmd
);
  logic              stb_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              load_en;

  assign load_en = launch_host || launch_sync;

  always_comb begin
    data_d = slot_data;
    cmd_d  = slot_cmd;
    if (launch_sync) begin
      data_d = '0;
      cmd_d  = SYNC_CODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      data_q <= '0;
      cmd_q  <= '0;
    end else begin
      stb_q <= load_en;
      if (load_en) begin
        data_q <= data_d;
        cmd_q  <= cmd_d;
      end
    end
  end

  assign wr_stb    = stb_q;
  assign wr_data   = data_q;
  assign wr_cmd    = cmd_q;
  assign wr_is_cmd = |cmd_q;
endmodule

// File: rtl/tx_tail_flush.sv
module tx_tail_flush #(
  parameter int               DATA_W    = 8,
  parameter int               CMD_W     = 4,
  parameter int               CNT_W     = 8,
  parameter logic [CMD_W-1:0] SYNC_CODE = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_idle_cycles,
  input  logic [CNT_W-1:0]  cfg_ack_delay,
  input  logic              host_stb,
  input  logic              host_eob,
  input  logic [DATA_W-1:0] host_data,
  input  logic [CMD_W-1:0]  host_cmd,
  output logic              host_ack,
  output logic              fifo_wr_stb,
  output logic [DATA_W-1:0] fifo_data,
  output logic [CMD_W-1:0]  fifo_cmd,
  output logic              fifo_is_cmd
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic                  slot_vld, slot_eob;
  logic [DATA_W-1:0]     slot_data;
  logic [CMD_W-1:0]      slot_cmd;
  logic                  launch_host, launch_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  tf_hold_slot #(.DATA_W(DATA_W), .CMD_W(CMD_W)) i_slot (
    .clk(clk), .rst_n(rst_int_n),
    .load(host_stb), .data_in(host_data), .cmd_in(host_cmd), .eob_in(host_eob),
    .take(launch_host),
    .vld(slot_vld), .data(slot_data), .cmd(slot_cmd), .eob(slot_eob)
  );

  tf_flush_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .host_stb(host_stb), .slot_vld(slot_vld), .slot_eob(slot_eob),
    .out_busy(fifo_wr_stb), .cfg_idle(cfg_idle_cycles),
    .launch_host(launch_host), .launch_sync(launch_sync)
  );

  tf_out_stage #(.DATA_W(DATA_W), .CMD_W(CMD_W), .SYNC_CODE(SYNC_CODE)) i_out (
    .clk(clk), .rst_n(rst_int_n),
    .launch_host(launch_host), .launch_sync(launch_sync),
    .slot_data(slot_data), .slot_cmd(slot_cmd),
    .wr_stb(fifo_wr_stb), .wr_data(fifo_data), .wr_cmd(fifo_cmd),
    .wr_is_cmd(fifo_is_cmd)
  );

  tf_ack_delay #(.CNT_W(CNT_W)) i_ack (
    .clk(clk), .rst_n(rst_int_n),
    .stb(host_stb), .cfg_delay(cfg_ack_delay), .ack(host_ack)
  );
endmodule

// File: rtl/tx_tail_flush_chk.sv
module tx_tail_flush_chk #(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_stb,
  input logic [CNT_W-1:0]  cfg_ack_delay,
  input logic              slot_vld,
  input logic              fifo_wr_stb,
  input logic [DATA_W-1:0] fifo_data,
  input logic [CMD_W-1:0]  fifo_cmd,
  input logic              host_ack
);
  // R5: every strobe is followed by a low cycle
  p_strobe_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_stb |=> !fifo_wr_stb);

  // R3: bus fields only move together with a strobe
  p_fields_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fifo_data) || !$stable(fifo_cmd)) |-> fifo_wr_stb);

  // R10: zero delay acknowledges on the next cycle
  p_ack_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stb && cfg_ack_delay == '0) |=> host_ack);

  // R2: a held write drains as soon as the strobe is low
  p_slot_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && !fifo_wr_stb) |=> fifo_wr_stb);

  // R9: a write held behind a strobe goes out one cycle later
  p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && fifo_wr_stb) |=> !fifo_wr_stb ##1 fifo_wr_stb);
endmodule

bind tx_tail_flush tx_tail_flush_chk #(
  .DATA_W(DATA_W), .CMD_W(CMD_W), .CNT_W(CNT_W)
) i_tx_tail_flush_chk (
  .clk(clk), .rst_n(rst_int_n), .host_stb(host_stb),
  .cfg_ack_delay(cfg_ack_delay), .slot_vld(slot_vld),
  .fifo_wr_stb(fifo_wr_stb), .fifo_data(fifo_data), .fifo_cmd(fifo_cmd),
  .host_ack(host_ack)
);

// File: tb/test_tx_tail_flush.sv
`timescale 1ns/1ps
module test_tx_tail_flush;
  localparam logic [3:0] SYNC = 4'h8;

  logic       clk;
  logic       rst_n;
  logic [7:0] cfg_idle, cfg_ack;
  logic       host_stb, host_eob;
  logic [7:0] host_data;
  logic [3:0] host_cmd;
  logic       host_ack, wr_stb, is_cmd;
  logic [7:0] wr_data;
  logic [3:0] wr_cmd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  tx_tail_flush i_tx_tail_flush (
    .clk(clk), .rst_n(rst_n),
    .cfg_idle_cycles(cfg_idle), .cfg_ack_delay(cfg_ack),
    .host_stb(host_stb), .host_eob(host_eob),
    .host_data(host_data), .host_cmd(host_cmd),
    .host_ack(host_ack), .fifo_wr_stb(wr_stb),
    .fifo_data(wr_data), .fifo_cmd(wr_cmd), .fifo_is_cmd(is_cmd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {data, cmd, eob, idle, ack_delay}
  localparam int NV = 8;
  localparam logic [28:0] VECS [NV] = '{
    {8'h3C, 4'h0, 1'b0, 8'd0, 8'd0},
    {8'h81, 4'h0, 1'b1, 8'd0, 8'd1},
    {8'h5A, 4'h0, 1'b1, 8'd1, 8'd2},
    {8'hFF, 4'h0, 1'b1, 8'd5, 8'd3},
    {8'h00, 4'h9, 1'b0, 8'd0, 8'd4},
    {8'h7E, 4'h0, 1'b1, 8'd3, 8'd0},
    {8'hC3, 4'h2, 1'b1, 8'd9, 8'd1},
    {8'h01, 4'h0, 1'b0, 8'd2, 8'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // Starts right after a negedge; the write is sampled at the next edge E0.
  task automatic run_vec(input logic [28:0] v);
    logic [7:0] d, n, dly;
    logic [3:0] c;
    logic       e;
    int s_i, len;
    {d, c, e, n, dly} = v;
    cfg_idle = n; cfg_ack = dly;
    host_data = d; host_cmd = c; host_eob = e; host_stb = 1'b1;
    s_i = e ? 1 + ((int'(n) + 1 > 2) ? int'(n) + 1 : 2) : -1;
    len = ((s_i > 0) ? s_i : 1) + 4;
    if (len < int'(dly) + 3) len = int'(dly) + 3;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      host_stb = 1'b0;
      if (i == 1) begin
        chk("R2 strobe", wr_stb, 1);
        chk("R2 data", wr_data, d);
        chk("R2 cmd", wr_cmd, c);
        chk("R4 is_cmd", is_cmd, (c != 0) ? 1 : 0);
      end else if (i == s_i) begin
        chk("R6 sync strobe", wr_stb, 1);
        chk("R6 sync cmd", wr_cmd, SYNC);
        chk("R6 sync data", wr_data, 0);
        chk("R4 sync is_cmd", is_cmd, 1);
      end else begin
        chk(e ? "R5 R6 idle" : "R7 no flush", wr_stb, 0);
      end
      chk("R10 ack", host_ack, (i == int'(dly)) ? 1 : 0);
    end
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; host_stb = 1'b0; host_eob = 1'b0;
    host_data = 8'h00; host_cmd = 4'h0; cfg_idle = 8'd0; cfg_ack = 8'd0;
    repeat (4) @(negedge clk);
    // R1: quiet during reset, even with a request presented
    host_stb = 1'b1; host_data = 8'hEE; host_cmd = 4'h3;
    @(negedge clk);
    chk("R1 stb", wr_stb, 0);
    chk("R1 ack", host_ack, 0);
    chk("R1 data", wr_data, 0);
    chk("R1 cmd", wr_cmd, 0);
    chk("R1 is_cmd", is_cmd, 0);
    host_stb = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 stb after release", wr_stb, 0);
    chk("R1 data after release", wr_data, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8: write inside the idle window cancels the flush
    cfg_idle = 8'd6; cfg_ack = 8'd0;
    host_data = 8'h11; host_cmd = 4'h0; host_eob = 1'b1; host_stb = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      host_stb = 1'b0;
      if (i == 2) begin
        host_stb = 1'b1; host_data = 8'h22; host_eob = 1'b0;
      end
      if (i == 1) chk("R8 first", wr_data, 8'h11);
      if (i == 4) chk("R8 second data", wr_data, 8'h22);
      chk("R8 strobes", wr_stb, (i == 1 || i == 4) ? 1 : 0);
    end

    // R9: write sampled at the flush launch edge waits behind SYNC
    cfg_idle = 8'd0;
    host_data = 8'h33; host_cmd = 4'h0; host_eob = 1'b1; host_stb = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      host_stb = 1'b0;
      if (i == 2) begin
        host_stb = 1'b1; host_data = 8'hA5; host_eob = 1'b0;
      end
      if (i == 3) chk("R9 sync first", wr_cmd, SYNC);
      if (i == 4) chk("R3 sync held", wr_cmd, SYNC);
      if (i == 5) chk("R9 held data", wr_data, 8'hA5);
      chk("R9 strobes", wr_stb, (i == 1 || i == 3 || i == 5) ? 1 : 0);
    end

    done = 1;
    summary();
  end
endmodule